// File: doc/BRIEF.md
# Page-Preserving DMA Address Counter

This block produces the transfer address for a single DMA channel. A start address is loaded, and each step then moves the address up or down by one transfer. Only the low part of the address counts. The upper part acts as a fixed page, and carries or borrows never pass into it. When the counter runs past the end of its range, it wraps to the other end of the same page.

The block has two transfer widths, chosen on every step. In byte mode the counter is bits 15:0, it steps by one, and the page (bits 23:16) covers 64 KB. In word mode the counter is bits 16:1, so the address moves by two. The page is then bits 23:17 and covers 128 KB, and bit 0 is forced to zero. This page-locked addressing is the only behaviour, so it is in effect as soon as reset ends.

Top module: `pgaddr_ctr`

## Requirements
- R1: While `rst` is high, `addr_out` is 000000h on the following clock edge.
- R2: A `load_en` pulse copies `load_addr` unchanged, including bit 0, into `addr_out` one clock later.
- R3: When `load_en` and `step_en` are both high in the same cycle, the load wins and the step is discarded.
- R4: In a byte step (`word_mode`=0) with `dir_down`=0, bits 15:0 increment modulo 2^16 and bits 23:16 keep their value. For example, 01FFFFh becomes 010000h.
- R5: In a byte step with `dir_down`=1, bits 15:0 decrement modulo 2^16 and bits 23:16 keep their value. For example, 020000h becomes 02FFFFh.
- R6: In a word step (`word_mode`=1) with `dir_down`=0, bits 16:1 increment modulo 2^16 and bits 23:17 keep their value. For example, 01FFFEh becomes 000000h.
- R7: In a word step with `dir_down`=1, bits 16:1 decrement modulo 2^16 and bits 23:17 keep their value. For example, 020000h becomes 03FFFEh.
- R8: After any word step, bit 0 of `addr_out` is 0. The counter field is taken from bits 16:1 of the previous address, so an odd address 000005h steps up to 000006h.
- R9: With `load_en` and `step_en` both low, `addr_out` holds its value.
- R10: `word_mode` is sampled separately on every step. A single address may be stepped as a word and then as a byte: 01FFFFh steps up as a word to 000000h, which then steps down as a byte to 00FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load the start address |
| load_addr | input | 24 | Start address to load |
| step_en | input | 1 | Advance the address by one transfer |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| word_mode | input | 1 | 0 selects byte steps, 1 selects word steps |
| addr_out | output | 24 | Current address, registered |

## Verification
Every result is registered once, so a load, a step or reset appears on `addr_out` exactly one clock edge after the cycle in which the strobe was presented. The bench changes its inputs on the falling edge and drops the strobe on the next falling edge. It compares at that same falling edge, after exactly one rising edge has captured the operation. Chains of steps, such as the mixed-width sequence, check the address after each step before driving the next one.

// File: rtl/pgaddr_pkg.sv
package pgaddr_pkg;
  localparam int unsigned PG_ADDR_W = 24;
  localparam int unsigned PG_CNT_W  = 16;

  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_width_e;
endpackage

// File: rtl/pgaddr_field_sel.sv
// Picks the counting field out of the current address for the chosen width.
module pgaddr_field_sel
  import pgaddr_pkg::*;
#(
  parameter int unsigned ADDR_W = PG_ADDR_W,
  parameter int unsigned CNT_W  = PG_CNT_W
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  xfer_width_e       width,
  output logic [CNT_W-1:0]  field
);
  always_comb begin
    if (width == XFER_WORD) field = cur_addr[CNT_W:1];
    else                    field = cur_addr[CNT_W-1:0];
  end
endmodule

// File: rtl/pgaddr_step_unit.sv
// Wrapping up/down step of the counting field; never produces a carry out.
module pgaddr_step_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] field_in,
  input  logic             down,
  output logic [CNT_W-1:0] field_out
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (down) field_out = field_in - ONE;
    else      field_out = field_in + ONE;
  end
endmodule

// File: rtl/pgaddr_merge.sv
// Rebuilds the full address from the untouched page bits and the new field.
module pgaddr_merge
  import pgaddr_pkg::*;
#(
  parameter int unsigned ADDR_W = PG_ADDR_W,
  parameter int unsigned CNT_W  = PG_CNT_W
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  field,
  input  xfer_width_e       width,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int unsigned PG_BYTE_LO = CNT_W;
  localparam int unsigned PG_WORD_LO = CNT_W + 1;

  logic [ADDR_W-1:0] byte_form;
  logic [ADDR_W-1:0] word_form;

  generate
    genvar b;
    for (b = 0; b < ADDR_W; b++) begin : g_bit
      if (b < PG_BYTE_LO) begin : g_byte_cnt
        assign byte_form[b] = field[b];
      end else begin : g_byte_pg
        assign byte_form[b] = cur_addr[b];
      end

      if (b == 0) begin : g_word_lsb
        assign word_form[b] = 1'b0;
      end else if (b < PG_WORD_LO) begin : g_word_cnt
        assign word_form[b] = field[b-1];
      end else begin : g_word_pg
        assign word_form[b] = cur_addr[b];
      end
    end
  endgenerate

  assign next_addr = (width == XFER_WORD) ? word_form : byte_form;
endmodule

// File: rtl/pgaddr_ctr.sv
module pgaddr_ctr
  import pgaddr_pkg::*;
#(
  parameter int unsigned ADDR_W = PG_ADDR_W,
  parameter int unsigned CNT_W  = PG_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step_en,
  input  logic              dir_down,
  input  logic              word_mode,
  output logic [ADDR_W-1:0] addr_out
);
  xfer_width_e       width;
  logic [CNT_W-1:0]  cur_field;
  logic [CNT_W-1:0]  new_field;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] addr_q;

  assign width = word_mode ? XFER_WORD : XFER_BYTE;

  pgaddr_field_sel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sel (
    .cur_addr (addr_q),
    .width    (width),
    .field    (cur_field)
  );

  pgaddr_step_unit #(.CNT_W(CNT_W)) u_step (
    .field_in  (cur_field),
    .down      (dir_down),
    .field_out (new_field)
  );

  pgaddr_merge #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_merge (
    .cur_addr  (addr_q),
    .field     (new_field),
    .width     (width),
    .next_addr (stepped)
  );

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (load_en) addr_q <= load_addr;
    else if (step_en) addr_q <= stepped;
  end

  assign addr_out = addr_q;
endmodule

// File: rtl/pgaddr_ctr_chk.sv
module pgaddr_ctr_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_addr,
  input logic              step_en,
  input logic              word_mode,
  input logic [ADDR_W-1:0] addr_out
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> addr_out == '0);

  // R2 and R3: a load lands unchanged even if a step is requested alongside
  a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_en |=> addr_out == $past(load_addr));

  a_r4_byte_page_kept: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && !word_mode)
      |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]));

  a_r6_word_page_kept: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && word_mode)
      |=> addr_out[ADDR_W-1:CNT_W+1] == $past(addr_out[ADDR_W-1:CNT_W+1]));

  a_r8_word_even: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && word_mode) |=> !addr_out[0]);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !load_en) |=> $stable(addr_out));
endmodule

bind pgaddr_ctr pgaddr_ctr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load_en   (load_en),
  .load_addr (load_addr),
  .step_en   (step_en),
  .word_mode (word_mode),
  .addr_out  (addr_out)
);

// File: tb/pgaddr_ctr_tb.sv
`timescale 1ns/1ps
module pgaddr_ctr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [23:0] load_addr = '0;
  logic        step_en = 1'b0;
  logic        dir_down = 1'b0;
  logic        word_mode = 1'b0;
  logic [23:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pgaddr_ctr u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .step_en(step_en), .dir_down(dir_down), .word_mode(word_mode),
    .addr_out(addr_out)
  );

  // {start(24), dir_down(1), word_mode(1), expected(24)}
  localparam int NV = 10;
  localparam logic [49:0] VEC [NV] = '{
    {24'h01FFFF, 1'b0, 1'b0, 24'h010000},  // R4
    {24'h020000, 1'b1, 1'b0, 24'h02FFFF},  // R5
    {24'h01FFFE, 1'b0, 1'b1, 24'h000000},  // R6
    {24'h020000, 1'b1, 1'b1, 24'h03FFFE},  // R7
    {24'h123456, 1'b0, 1'b0, 24'h123457},  // R4
    {24'hAB0000, 1'b1, 1'b0, 24'hABFFFF},  // R5
    {24'h000005, 1'b0, 1'b1, 24'h000006},  // R8
    {24'h000001, 1'b1, 1'b1, 24'h01FFFE},  // R8
    {24'hFE1234, 1'b1, 1'b1, 24'hFE1232},  // R7
    {24'h7FFFFE, 1'b0, 1'b1, 24'h7E0000}   // R6
  };
  localparam string VTAG [NV] = '{"R4", "R5", "R6", "R7", "R4", "R5",
                                  "R8", "R8", "R7", "R6"};

  task automatic check(input string req, input logic [23:0] exp);
    n_chk++;
    if (addr_out !== exp) begin
      n_bad++;
      $display("FAIL %s: addr_out=%06h expected=%06h", req, addr_out, exp);
    end
  endtask

  task automatic do_load(input logic [23:0] a);
    @(negedge clk);
    load_en = 1'b1; load_addr = a;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic do_step(input logic dn, input logic wm);
    @(negedge clk);
    step_en = 1'b1; dir_down = dn; word_mode = wm;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 24'h000000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][49:26]);
      check("R2 load", VEC[i][49:26]);
      do_step(VEC[i][25], VEC[i][24]);
      check(VTAG[i], VEC[i][23:0]);
    end

    // R9: idle cycles keep the address
    do_load(24'h5A5A5A);
    repeat (4) @(negedge clk);
    check("R9 hold", 24'h5A5A5A);

    // R3: load and step together, load wins
    @(negedge clk);
    load_en = 1'b1; load_addr = 24'h3C0FFF; step_en = 1'b1; word_mode = 1'b0;
    @(negedge clk);
    load_en = 1'b0; step_en = 1'b0;
    check("R3 load priority", 24'h3C0FFF);

    // R10: width sampled per step
    do_load(24'h01FFFF);
    do_step(1'b0, 1'b1);
    check("R10 word step", 24'h000000);
    do_step(1'b1, 1'b0);
    check("R10 byte step", 24'h00FFFF);
    do_step(1'b0, 1'b0);
    check("R4 wrap chain", 24'h000000);

    // R1: reset mid-run clears address
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset again", 24'h000000);

    finish_run();
  end
endmodule